// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock and data) and delivers one left and one right sample per frame in the master-clock domain. A static format pin selects between two framings. In left-justified framing the first data bit of a channel follows the frame-clock edge at once. In I2S framing it comes one bit later, and the frame-clock level that marks the left channel is inverted. A two-bit setting selects the word length: 16, 18, 20 or 24 bits.

All three serial inputs are brought into the master-clock domain through synchronizer chains, and bit-clock edges are found there. The master clock must therefore run at least four times faster than the bit clock. Each sample is placed MSB-aligned in a 24-bit word with zeros below the word. A single-cycle strobe reports that a complete left-then-right frame is available.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and in the cycle after it, both sample outputs are zero and the strobe is low.
- R2: With the format pin low (left-justified), frame clock high marks the left channel. The MSB of a channel is the bit taken at the first rising bit-clock edge after a frame-clock transition.
- R3: With the format pin high (I2S), frame clock low marks the left channel. The MSB is the bit taken at the second rising bit-clock edge after the transition.
- R4: The word-length setting selects the number of bits captured per channel: 00 selects 16, 01 selects 18, 10 selects 20 and 11 selects 24. Bits are taken MSB first on rising bit-clock edges.
- R5: Each sample is MSB-aligned in bits 23 down to 24 minus the word length, and the bits below are zero. Slot bits after the word length do not affect the outputs.
- R6: Exactly one single-cycle strobe is raised for each frame, once the right word of a frame has been captured after the left word of the same frame.
- R7: The sample outputs change only in the cycle in which the strobe is high, and hold their value at all other times.
- R8: After reset, or after any change of format or word length, no strobe is raised until a frame-clock transition has occurred and a full left word and then a full right word have been captured.
- R9: Capture is correct for asynchronous serial inputs with a bit-clock period as short as four master-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| fclk_in | input | 1 | Frame (left/right) clock, asynchronous |
| sdat_in | input | 1 | Serial data, asynchronous |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = left-justified |
| wlen_sel | input | 2 | Word length: 00=16, 01=18, 10=20, 11=24 |
| left_out | output | 24 | Left sample, MSB-aligned |
| right_out | output | 24 | Right sample, MSB-aligned |
| frame_valid | output | 1 | One-cycle strobe when a new frame is present |

## Verification
The bench fills the slot bits after each word with random junk. A design that does not stop at the selected word length would show that junk in the low bits. The bench runs both framings at all four lengths, including slots exactly as long as the word, where a one-bit error in the I2S delay would shift the whole sample or drop its LSB. It also changes the word length between the left and right halves of a frame, and it starts capture after reset in the middle of a frame. A design that failed to re-arm in those cases would emit a strobe with a mixed or partial frame. Runs at the shortest allowed bit-clock period catch a design whose edge detection misses edges or samples data out of step with the clock.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                fclk_in,
  input  logic                sdat_in,
  input  logic                fmt_i2s,
  input  logic [1:0]          wlen_sel,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                frame_valid
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] bclk_sync, fclk_sync, sdat_sync;
  logic bclk_s, fclk_s, sdat_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sync <= '0;
      fclk_sync <= '0;
      sdat_sync <= '0;
    end else begin
      bclk_sync <= {bclk_sync[SYNC_STAGES-2:0], bclk_in};
      fclk_sync <= {fclk_sync[SYNC_STAGES-2:0], fclk_in};
      sdat_sync <= {sdat_sync[SYNC_STAGES-2:0], sdat_in};
    end
  end

  assign bclk_s = bclk_sync[TOP];
  assign fclk_s = fclk_sync[TOP];
  assign sdat_s = sdat_sync[TOP];

  logic                bclk_d, fclk_prev, fclk_seen, armed, left_done;
  logic [CNT_W-1:0]    bit_cnt;
  logic [SAMPLE_W-1:0] acc, left_hold;
  logic [2:0]          cfg_q;

  logic                rise, cfg_chg, ws_flip, is_left, in_word, last, armed_now;
  logic [CNT_W-1:0]    idx, pos, dly, wbits;
  logic [SAMPLE_W-1:0] acc_new;

  assign rise      = bclk_s & ~bclk_d;
  assign cfg_chg   = {fmt_i2s, wlen_sel} != cfg_q;
  assign ws_flip   = fclk_seen && (fclk_s != fclk_prev);
  assign is_left   = fmt_i2s ? ~fclk_s : fclk_s;
  assign dly       = {{(CNT_W-1){1'b0}}, fmt_i2s};
  assign idx       = ws_flip ? '0 : bit_cnt;
  assign pos       = idx - dly;
  assign in_word   = (idx >= dly) && (pos < wbits);
  assign last      = in_word && (pos == wbits - 1'b1);
  assign armed_now = armed | ws_flip;

  always_comb begin
    case (wlen_sel)
      2'b00:   wbits = CNT_W'(16);
      2'b01:   wbits = CNT_W'(18);
      2'b10:   wbits = CNT_W'(20);
      default: wbits = CNT_W'(24);
    endcase
  end

  always_comb begin
    acc_new = ws_flip ? '0 : acc;
    if (in_word)
      acc_new[SAMPLE_W-1-int'(pos)] = sdat_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d      <= 1'b0;
      fclk_prev   <= 1'b0;
      fclk_seen   <= 1'b0;
      armed       <= 1'b0;
      left_done   <= 1'b0;
      bit_cnt     <= '0;
      acc         <= '0;
      left_hold   <= '0;
      cfg_q       <= 3'b000;
      left_out    <= '0;
      right_out   <= '0;
      frame_valid <= 1'b0;
    end else begin
      bclk_d      <= bclk_s;
      cfg_q       <= {fmt_i2s, wlen_sel};
      frame_valid <= 1'b0;
      if (rise) begin
        fclk_prev <= fclk_s;
        fclk_seen <= 1'b1;
        bit_cnt   <= (idx == '1) ? idx : idx + 1'b1;
        acc       <= acc_new;
      end
      if (cfg_chg) begin
        armed     <= 1'b0;
        left_done <= 1'b0;
      end else if (rise) begin
        if (ws_flip) armed <= 1'b1;
        if (ws_flip && is_left) left_done <= 1'b0;
        if (last && armed_now) begin
          if (is_left) begin
            left_hold <= acc_new;
            left_done <= 1'b1;
          end else if (left_done) begin
            left_out    <= left_hold;
            right_out   <= acc_new;
            frame_valid <= 1'b1;
            left_done   <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fmt_i2s,
  input logic [1:0]  wlen_sel,
  input logic [23:0] left_out,
  input logic [23:0] right_out,
  input logic        frame_valid
);

  function automatic logic [23:0] low_mask(input logic [1:0] s);
    case (s)
      2'b00:   return 24'h0000FF;
      2'b01:   return 24'h00003F;
      2'b10:   return 24'h00000F;
      default: return 24'h000000;
    endcase
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!frame_valid && left_out == 24'd0 && right_out == 24'd0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_out) |-> frame_valid);

  a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_out) |-> frame_valid);

  a_r8_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(fmt_i2s) || $changed(wlen_sel)) |=> !frame_valid);

  a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (((left_out | right_out) & low_mask(wlen_sel)) == 24'd0));

endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .wlen_sel(wlen_sel),
  .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
);

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fclk = 1'b0, sdat = 1'b0, fmt = 1'b0;
  logic [1:0] wsel = 2'b11;
  logic [23:0] left_out, right_out;
  logic frame_valid;

  int vectors = 0, errors = 0, half = 4, nstb = 0;
  logic [23:0] got_l, got_r;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fclk_in(fclk), .sdat_in(sdat),
    .fmt_i2s(fmt), .wlen_sel(wsel), .left_out(left_out), .right_out(right_out),
    .frame_valid(frame_valid)
  );

  always @(negedge clk)
    if (rst_n && frame_valid) begin
      nstb++;
      got_l = left_out;
      got_r = right_out;
    end

  function automatic int wbits_of(input logic [1:0] s);
    case (s)
      2'b00: return 16;
      2'b01: return 18;
      2'b10: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] keep(input logic [23:0] w, input logic [1:0] s);
    logic [23:0] m;
    m = ~(24'hFFFFFF >> wbits_of(s));
    return w & m;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_slot(input logic ws, input logic [23:0] w, input int slot);
    int d;
    d = fmt ? 1 : 0;
    for (int i = 0; i < slot; i++) begin
      int p;
      p = i - d;
      fclk = ws;
      if (p >= 0 && p < wbits_of(wsel)) sdat = w[23-p];
      else sdat = 1'($urandom);
      tick(half);
      bclk = 1'b1;
      tick(half);
      bclk = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int slot);
    send_slot(fmt ? 1'b0 : 1'b1, l, slot);
    send_slot(fmt ? 1'b1 : 1'b0, r, slot);
  endtask

  task automatic run_frame(input logic [23:0] l, input logic [23:0] r, input int slot);
    string tg;
    tg = fmt ? "R3" : "R2";
    nstb = 0;
    send_frame(l, r, slot);
    tick(12);
    check(nstb == 1, "R6 strobe count", 24'(nstb), 24'd1);
    check(got_l == keep(l, wsel), {tg, " R4 R5 R9 left"}, got_l, keep(l, wsel));
    check(got_r == keep(r, wsel), {tg, " R4 R5 R9 right"}, got_r, keep(r, wsel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    fclk = 1'b1;
    tick(4);
    check(!frame_valid, "R1 strobe in reset", 24'(frame_valid), 24'd0);
    check(left_out == 0 && right_out == 0, "R1 outputs in reset", left_out | right_out, 24'd0);
    rst_n = 1'b1;
    tick(1);
    check(left_out == 0 && right_out == 0 && !frame_valid, "R1 after reset", left_out | right_out, 24'd0);

    nstb = 0;
    send_slot(1'b1, 24'hABCDEF, 32);
    send_slot(1'b0, 24'h123456, 32);
    tick(12);
    check(nstb == 0, "R8 no strobe before armed frame", 24'(nstb), 24'd0);
    run_frame(24'h800001, 24'h7FFFFE, 32);

    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 4; s++) begin
        int tight;
        fmt = f[0];
        wsel = 2'(s);
        half = 2 + int'($urandom_range(2));
        tight = wbits_of(wsel) + f;
        send_frame(24'h0, 24'h0, 32);
        tick(12);
        run_frame(24'hFFFFFF, 24'h800000, tight);
        run_frame(24'h000000, 24'hFFFFFF, 32);
        for (int k = 0; k < 5; k++)
          run_frame(24'($urandom), 24'($urandom), (k % 2 == 0) ? 32 : tight);
        nstb = 0;
        send_slot(fmt ? 1'b0 : 1'b1, 24'h55AA55, 32);
        wsel = wsel ^ 2'b01;
        send_slot(fmt ? 1'b1 : 1'b0, 24'hAA55AA, 32);
        tick(12);
        check(nstb == 0, "R8 no strobe across config change", 24'(nstb), 24'd0);
        run_frame(24'($urandom), 24'($urandom), 32);
      end
    end

    half = 2;
    fmt = 1'b1;
    wsel = 2'b11;
    send_frame(24'h0, 24'h0, 32);
    tick(12);
    run_frame(24'h000001, 24'h000001, 25);
    run_frame(24'hC00003, 24'h3FFFFC, 25);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule